// File: doc/BRIEF.md
# Way-Partitioned Cache Allocation Controller

This block holds the tag state and the replacement logic of a set-associative last-level cache. The cache's ways are shared among several requester classes. Each class owns a way bitmask with one bit per way, and that mask limits only where the class may place new lines. Every lookup carries a class number, a set index and a tag. The tags of all ways in the set are compared, so a request may hit a line in any way, including ways its own class can no longer allocate into.

When a lookup misses, the response already names the way that a refill would replace. A refill is presented later on a valid/ready pair. Once the refill is accepted, the block picks a victim inside the class mask, writes the tag, sets the valid bit, and acknowledges one cycle later with the chosen way. Invalid allowed ways are used first. When every allowed way is full, a per-set tree pseudo-LRU walk is steered into the allowed ways.

A class whose mask is all zeros never allocates: its misses are flagged as bypass. The masks can be rewritten at any time through a one-cycle write port, so a more important class can be given a larger share of the ways. Lines already in the cache are never flushed by a mask change. The data array and the memory side are not part of this block.

Top module: `way_part_cache`

## Requirements
- R1: After reset all lines are invalid, every class mask is all ones, `rsp_valid` and `fill_ack` are low, and `fill_ready` is high while no lookup is presented.
- R2: A lookup presented with `req_valid` high at a clock edge produces exactly one response with `rsp_valid` high at the next edge. `rsp_hit` is high exactly when some way of that set holds a valid line with the same tag, and `rsp_way` then gives that way's index.
- R3: Hit detection ignores the class mask: a class hits a resident line in a way outside its mask, even when its mask is all zeros.
- R4: An accepted refill with a non-zero class mask writes exactly one way, and that way lies inside the mask of the refill's class. If some allowed way of the set is invalid, the lowest-numbered such way is chosen.
- R5: When every allowed way of the set is valid, the victim comes from a binary tree of WAYS-1 bits per set. The walk starts at the root. Each node bit selects the upper half when 1 and the lower half when 0, and the walk takes the other half when the selected half contains no allowed way. The walk ends at a leaf, which is the victim. A miss response reports in `rsp_victim` the way that a refill would pick at that moment.
- R6: For a class whose mask is all zeros, a miss returns `rsp_bypass` = 1 and `rsp_hit` = 0, and an accepted refill is acknowledged with `fill_bypass` = 1 and writes no line.
- R7: A mask write takes effect for lookups and refills from the next cycle on and invalidates no line. A line in a way that has become disallowed still hits.
- R8: `fill_ready` is low whenever `req_valid` is high, and a refill is accepted only when `fill_valid` and `fill_ready` are both high. `fill_ack` rises one cycle after acceptance and carries the chosen way in `fill_way`. The tag and the replacement state change only on an accepted refill or a hit.
- R9: A hit and an accepted allocating refill both touch the replacement tree of the set. On the path to the touched way, every node is set to point away from it (0 when the way lies in the upper half, 1 when it lies in the lower half).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a class mask |
| cfg_class | input | $clog2(CLASSES) | Class whose mask is written |
| cfg_mask | input | WAYS | New allocation mask, bit w enables way w |
| req_valid | input | 1 | Lookup request |
| req_class | input | $clog2(CLASSES) | Class of the lookup |
| req_set | input | $clog2(SETS) | Set index of the lookup |
| req_tag | input | TAG_W | Tag of the lookup |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | $clog2(WAYS) | Way that hit (0 on a miss) |
| rsp_victim | output | $clog2(WAYS) | Way a refill would replace (0 on a hit or bypass) |
| rsp_bypass | output | 1 | Miss by a class with an empty mask |
| fill_valid | input | 1 | Refill request |
| fill_ready | output | 1 | Refill can be accepted this cycle |
| fill_class | input | $clog2(CLASSES) | Class of the refill |
| fill_set | input | $clog2(SETS) | Set index of the refill |
| fill_tag | input | TAG_W | Tag written by the refill |
| fill_ack | output | 1 | Refill acknowledge |
| fill_way | output | $clog2(WAYS) | Way written by the acknowledged refill |
| fill_bypass | output | 1 | Acknowledged refill wrote nothing (empty mask) |

## Verification
The bound checker watches on every cycle the one-cycle lookup and refill timing, the ready rule against concurrent lookups, that an allocating refill's way lies inside the mask captured when the refill was accepted, and that a bypass is never a hit. The bench's scenarios cover what depends on stored history. These are hits from classes outside the owning mask, invalid-first choice, the tree victim order after a sequence of fills and hits, a refill that writes nothing for an empty mask, and a line that still hits after a mask shrinks. The bench also refuses a refill while a lookup is present and checks the victim after all sixteen ways are filled.

// File: rtl/cac_pkg.sv
`timescale 1ns/1ps
package cac_pkg;
  localparam int unsigned DEF_WAYS    = 16;
  localparam int unsigned DEF_SETS    = 64;
  localparam int unsigned DEF_CLASSES = 4;
  localparam int unsigned DEF_TAG_W   = 20;

  // Source of a replacement-tree update in a given cycle
  typedef enum logic [1:0] {TOUCH_NONE, TOUCH_HIT, TOUCH_FILL} touch_e;
endpackage

// File: rtl/cac_victim_sel.sv
`timescale 1ns/1ps
// Victim choice: lowest invalid allowed way, else masked tree walk.
module cac_victim_sel #(
  parameter int unsigned WAYS = 16,
  localparam int unsigned LVLS = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] valid,
  input  logic [WAYS-1:0] allow,
  input  logic [WAYS-2:0] tree,
  output logic [LVLS-1:0] way
);
  logic [WAYS-1:0]   free;
  logic [2*WAYS-1:1] anyv;
  logic [LVLS-1:0]   free_way;
  logic [LVLS-1:0]   tree_way;
  logic [LVLS:0]     node;
  logic              go;

  assign free = allow & ~valid;

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (free[w]) free_way = LVLS'(w);
    end
  end

  // anyv[n]: subtree rooted at heap node n holds at least one allowed way
  always_comb begin
    anyv = '0;
    for (int w = 0; w < WAYS; w++) anyv[WAYS + w] = allow[w];
    for (int n = WAYS - 1; n >= 1; n--) anyv[n] = anyv[2*n] | anyv[2*n + 1];
  end

  always_comb begin
    node = (LVLS+1)'(1);
    go   = 1'b0;
    for (int l = 0; l < LVLS; l++) begin
      go = tree[node - 1'b1];
      if (!anyv[{node[LVLS-1:0], go}]) go = ~go;
      node = {node[LVLS-1:0], go};
    end
    tree_way = node[LVLS-1:0];
  end

  assign way = (|free) ? free_way : tree_way;
endmodule

// File: rtl/cac_plru_update.sv
`timescale 1ns/1ps
// Tree update: every node on the path to the touched way points away from it.
module cac_plru_update #(
  parameter int unsigned WAYS = 16,
  localparam int unsigned LVLS = $clog2(WAYS)
) (
  input  logic [WAYS-2:0] tree_in,
  input  logic [LVLS-1:0] way,
  output logic [WAYS-2:0] tree_out
);
  logic [LVLS:0] node;
  logic          dir;

  always_comb begin
    tree_out = tree_in;
    node     = (LVLS+1)'(1);
    dir      = 1'b0;
    for (int l = 0; l < LVLS; l++) begin
      dir = way[LVLS-1-l];
      tree_out[node - 1'b1] = ~dir;
      node = {node[LVLS-1:0], dir};
    end
  end
endmodule

// File: rtl/way_part_cache.sv
`timescale 1ns/1ps
module way_part_cache
  import cac_pkg::*;
#(
  parameter int unsigned WAYS    = DEF_WAYS,
  parameter int unsigned SETS    = DEF_SETS,
  parameter int unsigned CLASSES = DEF_CLASSES,
  parameter int unsigned TAG_W   = DEF_TAG_W,
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned SET_W  = $clog2(SETS),
  localparam int unsigned CLS_W  = $clog2(CLASSES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CLS_W-1:0] cfg_class,
  input  logic [WAYS-1:0]  cfg_mask,
  input  logic             req_valid,
  input  logic [CLS_W-1:0] req_class,
  input  logic [SET_W-1:0] req_set,
  input  logic [TAG_W-1:0] req_tag,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [WAY_W-1:0] rsp_way,
  output logic [WAY_W-1:0] rsp_victim,
  output logic             rsp_bypass,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [CLS_W-1:0] fill_class,
  input  logic [SET_W-1:0] fill_set,
  input  logic [TAG_W-1:0] fill_tag,
  output logic             fill_ack,
  output logic [WAY_W-1:0] fill_way,
  output logic             fill_bypass
);
  // Storage
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-2:0]  plru_q  [SETS];
  logic [CLASSES-1:0][WAYS-1:0] mask_q;

  // Lookup path
  logic [WAYS-1:0]  hit_vec;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAYS-1:0]  look_mask;
  logic [WAY_W-1:0] look_victim;

  // Refill path
  logic [WAYS-1:0]  fill_mask;
  logic [WAY_W-1:0] fill_victim;
  logic             fill_fire;
  logic             fill_empty;

  // Replacement update
  touch_e           touch_src;
  logic [SET_W-1:0] touch_set;
  logic [WAY_W-1:0] touch_way;
  logic [WAYS-2:0]  plru_next;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[req_set][w] && (tag_q[req_set][w] == req_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign look_mask  = mask_q[req_class];
  assign fill_mask  = mask_q[fill_class];
  assign fill_empty = (fill_mask == '0);
  assign fill_ready = !req_valid;
  assign fill_fire  = fill_valid && fill_ready;

  cac_victim_sel #(.WAYS(WAYS)) u_look_victim (
    .valid (valid_q[req_set]),
    .allow (look_mask),
    .tree  (plru_q[req_set]),
    .way   (look_victim)
  );

  cac_victim_sel #(.WAYS(WAYS)) u_fill_victim (
    .valid (valid_q[fill_set]),
    .allow (fill_mask),
    .tree  (plru_q[fill_set]),
    .way   (fill_victim)
  );

  always_comb begin
    touch_src = TOUCH_NONE;
    touch_set = req_set;
    touch_way = hit_way;
    if (req_valid && hit) begin
      touch_src = TOUCH_HIT;
    end else if (fill_fire && !fill_empty) begin
      touch_src = TOUCH_FILL;
      touch_set = fill_set;
      touch_way = fill_victim;
    end
  end

  cac_plru_update #(.WAYS(WAYS)) u_plru_upd (
    .tree_in  (plru_q[touch_set]),
    .way      (touch_way),
    .tree_out (plru_next)
  );

  // Control state: valid bits, trees, class masks
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        plru_q[s]  <= '0;
      end
      mask_q <= '1;
    end else begin
      if (cfg_we) mask_q[cfg_class] <= cfg_mask;
      if (touch_src != TOUCH_NONE) plru_q[touch_set] <= plru_next;
      if (touch_src == TOUCH_FILL) valid_q[fill_set][fill_victim] <= 1'b1;
    end
  end

  // Tag array: write-only on allocating refill, no reset
  always_ff @(posedge clk) begin
    if (fill_fire && !fill_empty) tag_q[fill_set][fill_victim] <= fill_tag;
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_way     <= '0;
      rsp_victim  <= '0;
      rsp_bypass  <= 1'b0;
      fill_ack    <= 1'b0;
      fill_way    <= '0;
      fill_bypass <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_hit     <= req_valid && hit;
      rsp_way     <= (req_valid && hit) ? hit_way : '0;
      rsp_bypass  <= req_valid && !hit && (look_mask == '0);
      rsp_victim  <= (req_valid && !hit && (look_mask != '0)) ? look_victim : '0;
      fill_ack    <= fill_fire;
      fill_bypass <= fill_fire && fill_empty;
      fill_way    <= (fill_fire && !fill_empty) ? fill_victim : '0;
    end
  end
endmodule

// File: rtl/cac_checker.sv
`timescale 1ns/1ps
module cac_checker #(
  parameter int unsigned WAYS    = 16,
  parameter int unsigned CLASSES = 4,
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned CLS_W  = $clog2(CLASSES)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_bypass,
  input logic             fill_valid,
  input logic             fill_ready,
  input logic [CLS_W-1:0] fill_class,
  input logic             fill_ack,
  input logic [WAY_W-1:0] fill_way,
  input logic             fill_bypass,
  input logic [CLASSES-1:0][WAYS-1:0] mask_q
);
  // Mask of the class whose refill was accepted in the previous cycle
  logic [WAYS-1:0] acc_mask_q;

  always_ff @(posedge clk) begin
    if (rst) acc_mask_q <= '0;
    else if (fill_valid && fill_ready) acc_mask_q <= mask_q[fill_class];
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R8
  ready_yields_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !fill_ready);

  // R8
  ack_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_valid && fill_ready) |=> fill_ack);

  // R8
  no_spurious_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !(fill_valid && fill_ready) |=> !fill_ack);

  // R4
  fill_in_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_ack && !fill_bypass) |-> acc_mask_q[fill_way]);

  // R6
  fill_bypass_empty_chk: assert property (@(posedge clk) disable iff (rst)
    fill_ack |-> (fill_bypass == (acc_mask_q == '0)));

  // R6
  bypass_not_hit_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_bypass |-> (rsp_valid && !rsp_hit));
endmodule

bind way_part_cache cac_checker #(.WAYS(WAYS), .CLASSES(CLASSES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_bypass  (rsp_bypass),
  .fill_valid  (fill_valid),
  .fill_ready  (fill_ready),
  .fill_class  (fill_class),
  .fill_ack    (fill_ack),
  .fill_way    (fill_way),
  .fill_bypass (fill_bypass),
  .mask_q      (mask_q)
);

// File: tb/tb_way_part_cache.sv
`timescale 1ns/1ps
module tb_way_part_cache;
  localparam int WAYS = 16, SETS = 64, CLASSES = 4, TAG_W = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_class = '0;
  logic [15:0] cfg_mask = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_class = '0;
  logic [5:0]  req_set = '0;
  logic [19:0] req_tag = '0;
  logic        rsp_valid, rsp_hit, rsp_bypass;
  logic [3:0]  rsp_way, rsp_victim;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [1:0]  fill_class = '0;
  logic [5:0]  fill_set = '0;
  logic [19:0] fill_tag = '0;
  logic        fill_ack, fill_bypass;
  logic [3:0]  fill_way;

  always #2 clk = ~clk;

  way_part_cache #(.WAYS(WAYS), .SETS(SETS), .CLASSES(CLASSES), .TAG_W(TAG_W)) dut (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_class(cfg_class), .cfg_mask(cfg_mask),
    .req_valid(req_valid), .req_class(req_class), .req_set(req_set), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_victim(rsp_victim), .rsp_bypass(rsp_bypass),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_class(fill_class),
    .fill_set(fill_set), .fill_tag(fill_tag),
    .fill_ack(fill_ack), .fill_way(fill_way), .fill_bypass(fill_bypass)
  );

  typedef struct packed {
    logic       hit;
    logic [3:0] way;
    logic [3:0] victim;
    logic       byp;
  } rsp_exp_t;

  typedef struct packed {
    logic [3:0] way;
    logic       byp;
  } ack_exp_t;

  rsp_exp_t rq[$];
  string    rq_tag[$];
  ack_exp_t aq[$];
  string    aq_tag[$];

  int checks = 0;
  int fails  = 0;

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  // Monitor: pops expected items as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        if (rq.size() == 0) begin
          chk("R2", "unexpected response", 1, 0);
        end else begin
          rsp_exp_t e;
          string r;
          e = rq.pop_front();
          r = rq_tag.pop_front();
          chk(r, "rsp_hit", int'(rsp_hit), int'(e.hit));
          chk(r, "rsp_bypass", int'(rsp_bypass), int'(e.byp));
          if (e.hit) chk(r, "rsp_way", int'(rsp_way), int'(e.way));
          else if (!e.byp) chk(r, "rsp_victim", int'(rsp_victim), int'(e.victim));
        end
      end
      if (!rst && fill_ack) begin
        if (aq.size() == 0) begin
          chk("R8", "unexpected fill_ack", 1, 0);
        end else begin
          ack_exp_t a;
          string r;
          a = aq.pop_front();
          r = aq_tag.pop_front();
          chk(r, "fill_bypass", int'(fill_bypass), int'(a.byp));
          if (!a.byp) chk(r, "fill_way", int'(fill_way), int'(a.way));
        end
      end
    end
  end

  task automatic lookup(int cls, int set, int tag, bit hit, int way, int victim,
                        bit byp, string r);
    rsp_exp_t e;
    e.hit = hit; e.way = 4'(way); e.victim = 4'(victim); e.byp = byp;
    rq.push_back(e);
    rq_tag.push_back(r);
    @(negedge clk);
    req_valid = 1'b1;
    req_class = 2'(cls);
    req_set   = 6'(set);
    req_tag   = 20'(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic refill(int cls, int set, int tag, int way, bit byp, string r);
    ack_exp_t a;
    a.way = 4'(way); a.byp = byp;
    aq.push_back(a);
    aq_tag.push_back(r);
    @(negedge clk);
    fill_valid = 1'b1;
    fill_class = 2'(cls);
    fill_set   = 6'(set);
    fill_tag   = 20'(tag);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic set_mask(int cls, int mask);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_class = 2'(cls);
    cfg_mask  = 16'(mask);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    chk("R1", "rsp_valid", int'(rsp_valid), 0);
    chk("R1", "fill_ack", int'(fill_ack), 0);
    chk("R1", "fill_ready", int'(fill_ready), 1);
    // R1: empty cache, full mask -> miss, victim way 0
    lookup(0, 3, 'h111, 0, 0, 0, 0, "R1");

    // R4: first refill lands in way 0; R2: hit reported with way
    refill(0, 3, 'h111, 0, 0, "R4");
    lookup(2, 3, 'h111, 1, 0, 0, 0, "R2");
    lookup(0, 3, 'h222, 0, 0, 1, 0, "R4");

    set_mask(1, 'h0030);
    set_mask(2, 'hFF00);
    set_mask(3, 'h0000);

    // R4: lowest invalid way inside mask FF00 is 8
    refill(2, 7, 'hA0, 8, 0, "R4");
    // R3: hit from classes whose masks exclude way 8
    lookup(1, 7, 'hA0, 1, 8, 0, 0, "R3");
    lookup(3, 7, 'hA0, 1, 8, 0, 0, "R3");

    // R4/R5/R9: two-way partition {4,5}
    refill(1, 9, 'h91, 4, 0, "R4");
    refill(1, 9, 'h92, 5, 0, "R4");
    lookup(1, 9, 'h93, 0, 0, 4, 0, "R5");
    lookup(0, 9, 'h91, 1, 4, 0, 0, "R9");
    lookup(1, 9, 'h93, 0, 0, 5, 0, "R9");
    refill(1, 9, 'h93, 5, 0, "R5");
    lookup(1, 9, 'h92, 0, 0, 4, 0, "R5");
    lookup(1, 9, 'h93, 1, 5, 0, 0, "R5");

    // R6: empty mask -> bypass, nothing written
    lookup(3, 9, 'h94, 0, 0, 0, 1, "R6");
    refill(3, 9, 'h94, 0, 1, "R6");
    lookup(0, 9, 'h94, 0, 0, 0, 0, "R6");

    // R7: shrink class 2 to low half; resident line still hits
    set_mask(2, 'h00FF);
    lookup(2, 7, 'hA0, 1, 8, 0, 0, "R7");
    refill(2, 7, 'hA1, 0, 0, "R7");
    lookup(0, 7, 'hA1, 1, 0, 0, 0, "R7");

    // R8: refill held off while a lookup is present
    begin
      rsp_exp_t e;
      ack_exp_t a;
      e.hit = 1'b0; e.way = 4'd0; e.victim = 4'd0; e.byp = 1'b0;
      rq.push_back(e); rq_tag.push_back("R8");
      a.way = 4'd0; a.byp = 1'b0;
      aq.push_back(a); aq_tag.push_back("R8");
      @(negedge clk);
      req_valid = 1'b1; req_class = 2'd0; req_set = 6'd30; req_tag = 20'h3A;
      fill_valid = 1'b1; fill_class = 2'd0; fill_set = 6'd30; fill_tag = 20'h3A;
      #1 chk("R8", "fill_ready during lookup", int'(fill_ready), 0);
      @(negedge clk);
      req_valid = 1'b0;
      #1 chk("R8", "fill_ready when idle", int'(fill_ready), 1);
      @(negedge clk);
      fill_valid = 1'b0;
    end
    lookup(0, 30, 'h3A, 1, 0, 0, 0, "R8");

    // R4/R5: fill all sixteen ways of set 20, then the tree names way 0
    for (int i = 0; i < 16; i++) refill(0, 20, 'h200 + i, i, 0, "R4");
    lookup(0, 20, 'h2FF, 0, 0, 0, 0, "R5");
    lookup(0, 20, 'h20F, 1, 15, 0, 0, "R2");

    repeat (4) @(negedge clk);
    chk("R2", "responses outstanding", rq.size(), 0);
    chk("R8", "acks outstanding", aq.size(), 0);
    finish_run();
  end
endmodule